// File: doc/BRIEF.md
# Windowed Pixel Output Multiplexer with Latency-Matched Color Bypass

This block is the last stage of a raster pixel pipeline. Each accepted beat carries an incoming raster pixel, a locally expanded pixel that is aligned with it, and the horizontal and vertical sync flags of the raster. The block keeps track of the column and line of every beat from the sync flags. Inside a programmable rectangle it sends out the expanded pixel, and everywhere else it sends out the raster pixel. So the expanded picture shows up as a window on the live raster.

The expanded pixels can be passed through a color-space stage, which is selected beat by beat with `csc_on`. That choice is taken in the same cycle as the window choice, so the color handling of the windowed content never depends on the color space of the raster pixels. The color stage is a fixed-latency placeholder that reverses the order of the pixel components. A shift register of equal depth runs beside it. Every beat therefore leaves after the same number of pipeline advances, whichever path it took, and the sync flags travel in the same pipeline as the pixel they belong to.

Both edges use valid/ready. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output holds no beat or the consumer is taking one, so the whole pipeline stops as a unit under back-pressure. While stopped, the output beat is held unchanged and no new input is accepted. Cycles without an input beat go down the pipeline as empty slots.

Top module: `pxo_window_mux`

## Requirements
- R1: An accepted beat whose column lies in [win_col_lo, win_col_hi] and whose line lies in [win_line_lo, win_line_hi] (bounds inclusive) carries the expanded pixel on the output. Every other beat carries its raster pixel.
- R2: An accepted beat with `in_hs` high is at column 0. If `in_vs` is also high, that beat is at line 0. If `in_vs` is low, the line is one more than before. An accepted beat with `in_hs` low is one column to the right of the previous beat and on the same line. `in_vs` without `in_hs` has no effect.
- R3: A windowed beat accepted with `csc_on` high leaves as the expanded pixel with its components in reverse order (component k at bits k*CW upward moves to position NC-1-k). `csc_on` has no effect on beats outside the window, and its value can differ from one beat to the next.
- R4: With `out_ready` held high, every accepted beat appears on the output exactly CSC_LAT+2 cycles after it is accepted, whether or not it went through the color stage.
- R5: `out_hs` and `out_vs` come out with the beat they were accepted with. Both are low whenever `out_valid` is low.
- R6: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. During such a stall, `out_pix`, `out_hs`, `out_vs` and `out_valid` stay stable and no beat is lost.
- R7: Cycles without an accepted beat produce no output beat and do not move the column or line count.
- R8: While reset is asserted, `out_valid`, `out_hs`, `out_vs` and `out_pix` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_pix | input | CW*NC | Raster pixel |
| in_hs | input | 1 | Beat starts a line |
| in_vs | input | 1 | Together with in_hs: beat starts a frame |
| exp_pix | input | CW*NC | Expanded pixel aligned with the beat |
| csc_on | input | 1 | Send this beat's expanded pixel through the color stage |
| win_col_lo | input | POSW | First column of the window |
| win_col_hi | input | POSW | Last column of the window |
| win_line_lo | input | POSW | First line of the window |
| win_line_hi | input | POSW | Last line of the window |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_pix | output | CW*NC | Selected pixel |
| out_hs | output | 1 | Delayed line-start flag |
| out_vs | output | 1 | Delayed frame-start flag |

## Verification
The bench drives a continuous raster of several short lines. The window covers the two middle columns of a single line, so the beats just outside each edge separate inclusive bounds from exclusive ones and separate line gating from column gating. In this raster, `csc_on` changes from beat to beat inside the window and is also set outside it. This separates a correct per-beat color selection from a selection that lags by a beat or leaks out of the window. A second frame broken by empty cycles shows whether gaps move the position count or change the latency. A stalled burst shows whether the output holds and whether beats are kept or dropped under back-pressure.

// File: rtl/pxo_pkg.sv
package pxo_pkg;
  // Per-beat sideband carried beside the pixel through the pipeline
  typedef struct packed {
    logic vld;
    logic hs;
    logic vs;
    logic use_csc;
  } pxo_side_t;
endpackage

// File: rtl/pxo_shift.sv
module pxo_shift #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (adv) begin
          stg[0] <= din;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign dout = stg[DEPTH-1];

      // R6: a stopped pipeline keeps every stage, so the tap cannot move
      a_r6_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(dout));
    end
  endgenerate
endmodule

// File: rtl/pxo_csc_stub.sv
module pxo_csc_stub #(
  parameter int CW  = 8,
  parameter int NC  = 3,
  parameter int LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CW*NC-1:0] din,
  output logic [CW*NC-1:0] dout
);
  localparam int PW = CW * NC;

  logic [PW-1:0] swapped;

  // Placeholder transform: component order reversed
  for (genvar g = 0; g < NC; g++) begin : g_comp
    assign swapped[g*CW +: CW] = din[(NC-1-g)*CW +: CW];
  end

  pxo_shift #(.W(PW), .DEPTH(LAT)) u_lat (
    .clk(clk), .rst_n(rst_n), .adv(adv), .din(swapped), .dout(dout)
  );
endmodule

// File: rtl/pxo_winpos.sv
module pxo_winpos #(
  parameter int POSW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat,
  input  logic            hs,
  input  logic            vs,
  input  logic [POSW-1:0] col_lo,
  input  logic [POSW-1:0] col_hi,
  input  logic [POSW-1:0] line_lo,
  input  logic [POSW-1:0] line_hi,
  output logic            in_win
);
  logic [POSW-1:0] col_q, line_q, col_now, line_now;

  // Position of the beat now on the input, derived from the last one
  always_comb begin
    col_now  = hs ? '0 : col_q + 1'b1;
    line_now = line_q;
    if (hs) line_now = vs ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (beat) begin
      col_q  <= col_now;
      line_q <= line_now;
    end
  end

  assign in_win = (col_now >= col_lo) && (col_now <= col_hi) &&
                  (line_now >= line_lo) && (line_now <= line_hi);

  // R2: line start returns the column to zero
  a_r2_col_restart: assert property (@(posedge clk) disable iff (!rst_n)
    beat && hs |=> col_q == '0);
  // R2: other beats step one column
  a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !hs |=> col_q == $past(col_q) + 1'b1);
  // R2: frame start returns the line to zero
  a_r2_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
    beat && hs && vs |=> line_q == '0);
  // R7: idle cycles leave the position untouched
  a_r7_pos_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(col_q) && $stable(line_q));
endmodule

// File: rtl/pxo_window_mux.sv
module pxo_window_mux
  import pxo_pkg::*;
#(
  parameter int CW      = 8,
  parameter int NC      = 3,
  parameter int CSC_LAT = 3,
  parameter int POSW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW*NC-1:0] in_pix,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic [CW*NC-1:0] exp_pix,
  input  logic             csc_on,
  input  logic [POSW-1:0]  win_col_lo,
  input  logic [POSW-1:0]  win_col_hi,
  input  logic [POSW-1:0]  win_line_lo,
  input  logic [POSW-1:0]  win_line_hi,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CW*NC-1:0] out_pix,
  output logic             out_hs,
  output logic             out_vs
);
  localparam int PW = CW * NC;
  localparam int SW = $bits(pxo_side_t);

  logic          adv, beat, in_win;
  logic [PW-1:0] s0_pix, csc_d, byp_d;
  pxo_side_t     s0_side, side_d;
  logic [SW-1:0] side_raw;

  // Whole pipeline moves together; it stops only on a held output
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign beat     = in_valid && adv;

  pxo_winpos #(.POSW(POSW)) u_pos (
    .clk(clk), .rst_n(rst_n), .beat(beat), .hs(in_hs), .vs(in_vs),
    .col_lo(win_col_lo), .col_hi(win_col_hi),
    .line_lo(win_line_lo), .line_hi(win_line_hi), .in_win(in_win)
  );

  // Window select and color-path select are taken in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_pix  <= '0;
      s0_side <= '0;
    end else if (adv) begin
      s0_pix          <= in_win ? exp_pix : in_pix;
      s0_side.vld     <= in_valid;
      s0_side.hs      <= in_valid && in_hs;
      s0_side.vs      <= in_valid && in_vs;
      s0_side.use_csc <= in_valid && in_win && csc_on;
    end
  end

  pxo_csc_stub #(.CW(CW), .NC(NC), .LAT(CSC_LAT)) u_csc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .din(s0_pix), .dout(csc_d)
  );

  pxo_shift #(.W(PW), .DEPTH(CSC_LAT)) u_bypass (
    .clk(clk), .rst_n(rst_n), .adv(adv), .din(s0_pix), .dout(byp_d)
  );

  pxo_shift #(.W(SW), .DEPTH(CSC_LAT)) u_side (
    .clk(clk), .rst_n(rst_n), .adv(adv), .din(s0_side), .dout(side_raw)
  );
  assign side_d = pxo_side_t'(side_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_hs    <= 1'b0;
      out_vs    <= 1'b0;
    end else if (adv) begin
      out_valid <= side_d.vld;
      out_pix   <= side_d.use_csc ? csc_d : byp_d;
      out_hs    <= side_d.hs;
      out_vs    <= side_d.vs;
    end
  end

  // R6: a refused output beat is held unchanged
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) &&
                               $stable(out_hs) && $stable(out_vs));
  // R5: sync flags only travel on real beats
  a_r5_sync_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_hs && !out_vs);
endmodule

// File: tb/pxo_window_mux_test.sv
`timescale 1ns/1ps
module pxo_window_mux_test;
  localparam int CSC_LAT = 3;
  localparam int LAT     = CSC_LAT + 2;

  // {hs, vs, csc_on, kind}; kind 0 raster, 1 expanded, 2 expanded reversed
  localparam logic [4:0] VEC [20] = '{
    5'b11000, 5'b00100, 5'b00000, 5'b00000,
    5'b10100, 5'b00001, 5'b00110, 5'b00100,
    5'b10000, 5'b00100, 5'b00000, 5'b00000,
    5'b11000, 5'b00000, 5'b00000, 5'b00000,
    5'b10000, 5'b00110, 5'b00001, 5'b00000
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_hs = 0, in_vs = 0, csc_on = 0;
  logic [23:0] in_pix = '0, exp_pix = '0, out_pix;
  logic out_valid, out_ready = 1, out_hs, out_vs;

  int n_chk = 0, n_err = 0, sent = 0, rcvd = 0, cyc = 0;
  logic [23:0] exp_q [64];
  logic ehs_q [64], evs_q [64], lat_q [64];
  int drv_cyc [64];
  logic lat_chk = 1;
  logic [23:0] held;
  int first;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pxo_window_mux #(.CW(8), .NC(3), .CSC_LAT(CSC_LAT), .POSW(12)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_hs(in_hs), .in_vs(in_vs), .exp_pix(exp_pix),
    .csc_on(csc_on), .win_col_lo(12'd1), .win_col_hi(12'd2),
    .win_line_lo(12'd1), .win_line_hi(12'd1), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .out_hs(out_hs), .out_vs(out_vs)
  );

  function automatic logic [23:0] rev3(input logic [23:0] p);
    return {p[7:0], p[15:8], p[23:16]};
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input bit hs, input bit vs, input bit csc, input logic [1:0] kind);
    logic [23:0] ip, ep;
    ip = 24'h400000 | 24'(sent);
    ep = {8'h10 + 8'(sent), 8'h20 + 8'(sent), 8'h30 + 8'(sent)};
    exp_q[sent] = (kind == 2'd0) ? ip : (kind == 2'd1) ? ep : rev3(ep);
    ehs_q[sent] = hs; evs_q[sent] = vs; lat_q[sent] = lat_chk;
    in_valid = 1; in_pix = ip; exp_pix = ep; in_hs = hs; in_vs = vs; csc_on = csc;
    while (!in_ready) begin @(negedge clk); #1; end
    drv_cyc[sent] = cyc;
    sent++;
    @(negedge clk);
    in_valid = 0; in_hs = 0; in_vs = 0; csc_on = 0;
  endtask

  // Output monitor: sampled between edges, after input changes settle
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      check(out_pix == exp_q[rcvd], "R1 R2 R3 R7 pixel", out_pix, exp_q[rcvd]);
      check(out_hs == ehs_q[rcvd] && out_vs == evs_q[rcvd], "R5 sync",
            {out_hs, out_vs}, {ehs_q[rcvd], evs_q[rcvd]});
      if (lat_q[rcvd])
        check(cyc - drv_cyc[rcvd] == LAT, "R4 latency", cyc - drv_cyc[rcvd], LAT);
      rcvd++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(out_valid == 0, "R8 out_valid", out_valid, 0);
    check(out_pix == 0 && out_hs == 0 && out_vs == 0, "R8 outputs",
          {out_pix, out_hs, out_vs}, 0);
    check(in_ready == 1, "R8 in_ready", in_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // Continuous raster through the vector table (R1 R2 R3 R4 R5)
    for (int i = 0; i < 20; i++)
      send(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0]);

    // R7: new frame with empty cycles between beats
    send(1, 1, 0, 2'd0);
    send(1, 0, 0, 2'd0);
    repeat (2) @(negedge clk);
    send(0, 0, 0, 2'd1);
    repeat (3) @(negedge clk);
    send(0, 0, 1, 2'd2);
    @(negedge clk);
    send(0, 0, 1, 2'd0);
    repeat (LAT + 3) @(negedge clk);
    check(rcvd == sent, "R7 beats out", rcvd, sent);

    // R6: stalled burst
    lat_chk = 0;
    out_ready = 0;
    first = sent;
    send(1, 1, 0, 2'd0);
    send(1, 0, 1, 2'd0);
    send(0, 0, 0, 2'd1);
    send(0, 0, 1, 2'd2);
    repeat (LAT + 2) @(negedge clk);
    held = out_pix;
    check(out_valid == 1, "R6 valid held", out_valid, 1);
    check(in_ready == 0, "R6 ready low", in_ready, 0);
    check(out_pix == exp_q[first], "R6 head beat", out_pix, exp_q[first]);
    repeat (2) begin
      @(negedge clk);
      check(out_pix == held && out_valid == 1, "R6 stable", out_pix, held);
    end
    fork
      send(0, 0, 1, 2'd0);
      begin repeat (2) @(negedge clk); out_ready = 1; end
    join
    repeat (LAT + 6) @(negedge clk);
    check(rcvd == sent, "R6 no loss", rcvd, sent);
    check(out_valid == 0 && out_hs == 0 && out_vs == 0, "R5 R7 idle",
          {out_valid, out_hs, out_vs}, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule